// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block keeps the protection part of a serial flash status register: a direction bit, a three-bit protection level and a lock bit. It turns these bits into a protected address range over a 256 KiB array. The array is split into four 64 KiB blocks. The protected region grows from the top of the array when the direction bit is 0 and from the bottom when it is 1. The block also enforces the chip-erase rule: a whole-array erase needs every level bit to be clear.

A command front end uses the block in two ways. It forwards status-write requests, and the block accepts or refuses each one according to the hardware guard pin and the lock bit. It also sends every program, sector-erase or chip-erase request with its 24-bit address. The block answers each request one cycle later with a one-cycle grant or deny pulse. A request never changes the stored bits. The present register contents are always visible on the status outputs.

Top module: `flash_guard`

## Requirements
- R1: A synchronous reset clears the direction bit, all three level bits and the lock bit to 0. It also clears every pulse output.
- R2: A request raises exactly one of `req_grant` and `req_deny` for one cycle, in the cycle after it is sampled. When no request is sampled, both outputs stay low.
- R3: Level values 000, 100 and 101 protect nothing. Every program (kind 0) or sector-erase (kind 1) request is granted at any address.
- R4: With direction 0, level 001 protects block 3 (0x030000–0x03FFFF), level 010 protects blocks 2–3 and level 110 protects blocks 1–3. A program or sector erase that targets a protected block is denied, and one that targets any other block is granted.
- R5: With direction 1, level 001 protects block 0 (0x000000–0x00FFFF), level 010 protects blocks 0–1 and level 110 protects blocks 0–2. Requests are decided as in R4.
- R6: When level bits [1:0] are 11, all four blocks are protected, whatever the direction and level bit 2. Every program and sector erase is denied.
- R7: A chip erase (kind 2) is granted only when the level is 000. The direction and lock bits do not affect this decision.
- R8: Only address bits [17:0] take part in the decision. Bits [17:16] select the block, and bits [23:18] have no effect.
- R9: A status write is accepted when `hw_guard_n` is 1 or the stored lock bit is 0. All five bits then take the written values, and the new values show on the status outputs one cycle later.
- R10: A status write is refused when `hw_guard_n` is 0 and the lock bit is 1. All five bits keep their values, and `sr_rej` pulses for one cycle.
- R11: Program, erase and chip-erase requests never change the stored status bits.
- R12: A request of reserved kind 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_guard_n | input | 1 | Hardware guard pin. When low, it enables the lock bit |
| sr_wr_valid | input | 1 | Status-write request strobe |
| sr_wr_bottom | input | 1 | Direction bit to write (1 = protect from the bottom) |
| sr_wr_level | input | 3 | Protection level to write |
| sr_wr_lock | input | 1 | Lock bit to write |
| sr_rej | output | 1 | One-cycle pulse when a status write is refused |
| cur_bottom | output | 1 | Stored direction bit |
| cur_level | output | 3 | Stored protection level |
| cur_lock | output | 1 | Stored lock bit |
| req_valid | input | 1 | Program or erase request strobe |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | 24 | Byte address of the request |
| req_grant | output | 1 | One-cycle pulse when the request is allowed |
| req_deny | output | 1 | One-cycle pulse when the request is refused |

## Verification
All of the internal state is visible on the three status outputs one cycle after each write. A stored bit that is wrong therefore shows up right away on those outputs. It also shows up on the very next request, because a wrong decode flips a grant into a deny for a predictable set of blocks. The bench sweeps every direction, level, lock, request kind and block, with addresses at both edges of each block. Any decode fault appears within two cycles of the configuration that exposes it. A fault in the lock gating shows up as either a missing `sr_rej` pulse or status outputs that changed when they should have stayed put.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_kind_e;

  localparam int LEVEL_W = 3;

  typedef struct packed {
    logic               lock;
    logic               from_bottom;
    logic [LEVEL_W-1:0] level;
  } guard_bits_t;
endpackage

// File: rtl/fwp_status_reg.sv
module fwp_status_reg
  import fwp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic        guard_n,
  input  guard_bits_t wr_bits,
  output guard_bits_t bits_q,
  output logic        wr_rej_q
);
  logic frozen;
  assign frozen = !guard_n && bits_q.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q   <= '0;
      wr_rej_q <= 1'b0;
    end else begin
      wr_rej_q <= 1'b0;
      if (wr_valid) begin
        if (frozen) wr_rej_q <= 1'b1;
        else        bits_q   <= wr_bits;
      end
    end
  end
endmodule

// File: rtl/fwp_range_decode.sv
module fwp_range_decode
  import fwp_pkg::*;
#(
  parameter int NBLK_LOG2 = 2
) (
  input  logic                    from_bottom,
  input  logic [LEVEL_W-1:0]      level,
  output logic [(1<<NBLK_LOG2)-1:0] prot_mask,
  output logic                    chip_ok
);
  localparam int NBLK  = 1 << NBLK_LOG2;
  localparam int QTR   = NBLK / 4;
  localparam int CNT_W = NBLK_LOG2 + 1;

  logic [2:0]       quarters;
  logic [CNT_W-1:0] prot_cnt;

  always_comb begin
    case (level)
      3'b001:         quarters = 3'd1;
      3'b010:         quarters = 3'd2;
      3'b110:         quarters = 3'd3;
      3'b011, 3'b111: quarters = 3'd4;
      default:        quarters = 3'd0;
    endcase
  end

  assign prot_cnt = CNT_W'(quarters) * CNT_W'(QTR);
  assign chip_ok  = (level == '0);

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    localparam logic [CNT_W-1:0] BELOW = CNT_W'(i);
    localparam logic [CNT_W-1:0] ABOVE = CNT_W'(NBLK - 1 - i);
    assign prot_mask[i] = from_bottom ? (prot_cnt > BELOW) : (prot_cnt > ABOVE);
  end
endmodule

// File: rtl/fwp_req_judge.sv
module fwp_req_judge
  import fwp_pkg::*;
#(
  parameter int NBLK_LOG2 = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [1:0]                req_kind,
  input  logic [NBLK_LOG2-1:0]      blk_idx,
  input  logic [(1<<NBLK_LOG2)-1:0] prot_mask,
  input  logic                      chip_ok,
  output logic                      grant_q,
  output logic                      deny_q
);
  op_kind_e kind;
  logic     allow;

  assign kind = op_kind_e'(req_kind);

  always_comb begin
    case (kind)
      OP_PROG, OP_SECT: allow = !prot_mask[blk_idx];
      OP_CHIP:          allow = chip_ok;
      default:          allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= req_valid && allow;
      deny_q  <= req_valid && !allow;
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fwp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BLK_BITS  = 16,
  parameter int NBLK_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_guard_n,
  input  logic              sr_wr_valid,
  input  logic              sr_wr_bottom,
  input  logic [2:0]        sr_wr_level,
  input  logic              sr_wr_lock,
  output logic              sr_rej,
  output logic              cur_bottom,
  output logic [2:0]        cur_level,
  output logic              cur_lock,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_grant,
  output logic              req_deny
);
  localparam int NBLK   = 1 << NBLK_LOG2;
  localparam int IDX_HI = BLK_BITS + NBLK_LOG2;

  guard_bits_t            wr_bits, bits_q;
  logic [NBLK-1:0]        prot_mask;
  logic                   chip_ok;
  logic [NBLK_LOG2-1:0]   blk_idx;
  logic                   unused_addr;

  assign wr_bits     = '{lock: sr_wr_lock, from_bottom: sr_wr_bottom, level: sr_wr_level};
  assign blk_idx     = req_addr[IDX_HI-1:BLK_BITS];
  assign unused_addr = ^{req_addr[ADDR_W-1:IDX_HI], req_addr[BLK_BITS-1:0]};

  fwp_status_reg u_sreg (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (sr_wr_valid),
    .guard_n  (hw_guard_n),
    .wr_bits  (wr_bits),
    .bits_q   (bits_q),
    .wr_rej_q (sr_rej)
  );

  fwp_range_decode #(.NBLK_LOG2(NBLK_LOG2)) u_dec (
    .from_bottom (bits_q.from_bottom),
    .level       (bits_q.level),
    .prot_mask   (prot_mask),
    .chip_ok     (chip_ok)
  );

  fwp_req_judge #(.NBLK_LOG2(NBLK_LOG2)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .blk_idx   (blk_idx),
    .prot_mask (prot_mask),
    .chip_ok   (chip_ok),
    .grant_q   (req_grant),
    .deny_q    (req_deny)
  );

  assign cur_bottom = bits_q.from_bottom;
  assign cur_level  = bits_q.level;
  assign cur_lock   = bits_q.lock;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_guard_n,
  input logic              sr_wr_valid,
  input logic              sr_wr_bottom,
  input logic [2:0]        sr_wr_level,
  input logic              sr_wr_lock,
  input logic              sr_rej,
  input logic              cur_bottom,
  input logic [2:0]        cur_level,
  input logic              cur_lock,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_grant,
  input logic              req_deny
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (cur_level == 3'b000 && !cur_lock && !cur_bottom && !req_grant && !req_deny && !sr_rej)); // R1
  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst) req_valid |=> (req_grant != req_deny)); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !req_valid |=> (!req_grant && !req_deny)); // R2
  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (rst) (req_valid && cur_level[1:0] == 2'b11) |=> req_deny); // R6
  AST_CHIP_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 2'd2 && cur_level != 3'b000) |=> req_deny); // R7
  AST_WR_TAKEN: assert property (@(posedge clk) disable iff (rst) (sr_wr_valid && (hw_guard_n || !cur_lock)) |=> ({cur_lock, cur_bottom, cur_level} == $past({sr_wr_lock, sr_wr_bottom, sr_wr_level}) && !sr_rej)); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst) (!hw_guard_n && cur_lock) |=> $stable({cur_lock, cur_bottom, cur_level})); // R10
  AST_REJ_PULSE: assert property (@(posedge clk) disable iff (rst) (sr_wr_valid && !hw_guard_n && cur_lock) |=> sr_rej); // R10
  AST_REQ_NO_STATE: assert property (@(posedge clk) disable iff (rst) !sr_wr_valid |=> $stable({cur_lock, cur_bottom, cur_level})); // R11
  AST_RSVD_DENY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_kind == 2'd3) |=> req_deny); // R12
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_guard_n = 1'b1;
  logic        sr_wr_valid = 1'b0;
  logic        sr_wr_bottom = 1'b0;
  logic [2:0]  sr_wr_level = 3'b000;
  logic        sr_wr_lock = 1'b0;
  logic        sr_rej;
  logic        cur_bottom;
  logic [2:0]  cur_level;
  logic        cur_lock;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [23:0] req_addr = 24'h0;
  logic        req_grant;
  logic        req_deny;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_guard dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sr_write(input bit b, input bit [2:0] l, input bit k);
    @(negedge clk);
    sr_wr_valid = 1'b1; sr_wr_bottom = b; sr_wr_level = l; sr_wr_lock = k;
    @(negedge clk);
    sr_wr_valid = 1'b0;
  endtask

  task automatic request(input bit [1:0] kind, input bit [23:0] addr, output bit g, output bit d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    g = req_grant; d = req_deny;
  endtask

  function automatic bit exp_grant(input bit b, input bit [2:0] l, input bit [1:0] kind, input int blk);
    int n;
    bit prot;
    if (l[1:0] == 2'b11) n = 4;
    else if (l == 3'b001) n = 1;
    else if (l == 3'b010) n = 2;
    else if (l == 3'b110) n = 3;
    else n = 0;
    prot = b ? (blk < n) : (blk >= 4 - n);
    if (kind == 2'd3) return 1'b0;
    if (kind == 2'd2) return (l == 3'b000);
    return !prot;
  endfunction

  function automatic string tag_of(input bit b, input bit [2:0] l, input bit [1:0] kind);
    if (kind == 2'd3) return "R12";
    if (kind == 2'd2) return "R7";
    if (l[1:0] == 2'b11) return "R6";
    if (l == 3'b000 || l == 3'b100 || l == 3'b101) return "R3";
    return b ? "R5" : "R4";
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({cur_lock, cur_bottom, cur_level} == 5'b0, "R1 reset bits", {cur_lock, cur_bottom, cur_level}, 0);
    chk(!req_grant && !req_deny && !sr_rej, "R1 reset pulses", {req_grant, req_deny, sr_rej}, 0);

    // Full sweep of configuration x kind x block x edge
    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < 8; l++) begin
        for (int k = 0; k < 2; k++) begin
          sr_write(b[0], l[2:0], k[0]);
          chk({cur_lock, cur_bottom, cur_level} == {k[0], b[0], l[2:0]}, "R9 write",
              {cur_lock, cur_bottom, cur_level}, {k[0], b[0], l[2:0]});
          for (int kind = 0; kind < 4; kind++) begin
            for (int blk = 0; blk < 4; blk++) begin
              for (int e = 0; e < 2; e++) begin
                bit [5:0] up;
                bit eg;
                up = 6'(blk * 11 + e * 29 + kind * 7 + l);
                eg = exp_grant(b[0], l[2:0], kind[1:0], blk);
                request(kind[1:0], {up, blk[1:0], (e != 0) ? 16'hFFFF : 16'h0000}, g, d);
                chk(g == eg && d == !eg, tag_of(b[0], l[2:0], kind[1:0]), {g, d}, {eg, !eg});
              end
            end
          end
          // R11: requests left the state untouched
          chk({cur_lock, cur_bottom, cur_level} == {k[0], b[0], l[2:0]}, "R11 state kept",
              {cur_lock, cur_bottom, cur_level}, {k[0], b[0], l[2:0]});
        end
      end
    end

    // R2: no pulse without request
    sr_write(1'b0, 3'b001, 1'b0);
    @(negedge clk);
    chk(!req_grant && !req_deny, "R2 idle", {req_grant, req_deny}, 0);

    // R8: upper address bits ignored (level 001, top)
    request(2'd0, 24'hFF0000, g, d);
    chk(d && !g, "R8 0xFF0000 in block 3", {g, d}, 1);
    request(2'd0, 24'hFC0000, g, d);
    chk(g && !d, "R8 0xFC0000 in block 0", {g, d}, 2);
    request(2'd1, 24'h42FFFF, g, d);
    chk(g && !d, "R8 0x42FFFF in block 2", {g, d}, 2);

    // R9/R10: lock gating
    sr_write(1'b1, 3'b010, 1'b1);            // guard high, set lock
    chk(cur_lock && cur_level == 3'b010, "R9 lock set", {cur_lock, cur_level}, 4'b1010);
    hw_guard_n = 1'b0;
    sr_write(1'b0, 3'b000, 1'b0);
    chk(sr_rej, "R10 rej pulse", sr_rej, 1);
    chk({cur_lock, cur_bottom, cur_level} == 5'b11010, "R10 frozen",
        {cur_lock, cur_bottom, cur_level}, 5'b11010);
    @(negedge clk);
    chk(!sr_rej, "R10 rej one cycle", sr_rej, 0);
    request(2'd2, 24'h0, g, d);
    chk(d && !g, "R7 chip denied while locked", {g, d}, 1);
    hw_guard_n = 1'b1;
    sr_write(1'b0, 3'b000, 1'b1);            // guard high: lock ignored
    chk({cur_lock, cur_bottom, cur_level} == 5'b10000 && !sr_rej, "R9 guard high overrides lock",
        {cur_lock, cur_bottom, cur_level}, 5'b10000);
    request(2'd2, 24'h0, g, d);
    chk(g && !d, "R7 chip granted level 000 lock 1", {g, d}, 2);
    sr_write(1'b0, 3'b000, 1'b0);
    hw_guard_n = 1'b0;
    sr_write(1'b1, 3'b110, 1'b0);            // guard low, lock 0
    chk({cur_lock, cur_bottom, cur_level} == 5'b01110 && !sr_rej, "R9 guard low lock 0",
        {cur_lock, cur_bottom, cur_level}, 5'b01110);
    hw_guard_n = 1'b1;

    // R1: mid-run reset
    sr_write(1'b1, 3'b111, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk({cur_lock, cur_bottom, cur_level} == 5'b0, "R1 reset mid-run",
        {cur_lock, cur_bottom, cur_level}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule